// File: doc/BRIEF.md
# Cascadable synchronous presettable binary counter

This block is a wide synchronous up-counter built from identical 4-bit slices. Each slice holds a modulo-16 count and reacts only on the rising clock edge. It has an active-low clear, an active-low parallel load from a data nibble, and two count enables. The first enable is the "parallel" enable, which gates only counting. The second is the "trickle" enable, which gates counting and also qualifies the slice's terminal-count signal. The top module chains `SLICES` slices, so the counter is `4*SLICES` bits wide. Clear, load, clock and the split data bus go to every slice in parallel.

The parameter `LOOKAHEAD` selects how the slices are linked. In ripple mode, each slice's terminal count feeds the trickle enable of the next slice, and every parallel enable follows the global parallel enable. In lookahead mode, the terminal count of slice 0, gated with the global parallel enable, drives the parallel enable of every higher slice. The trickle enables still pass from slice to slice, so the ripple path has a full 16-clock cycle of slice 0 to settle. Both styles give the same count sequence and the same carry output.

Inside each slice a decoder picks one of four named modes: CLEAR, LOAD, COUNT and HOLD. Clear has the highest priority, then load, then count. HOLD applies when neither enable combination allows counting. Each clock edge moves the slice state as follows. In CLEAR the state goes to zero. In LOAD it takes the data nibble. In COUNT it goes to the state plus one, and 15 is followed by 0. In HOLD it keeps the same state.

Top module: `cnt_chain`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q_o` becomes all zeros after that edge, whatever `ld_n`, `data_i` and the enables are.
- R2: When `clr_n` is high and `ld_n` is low at a rising edge, `q_o` takes the value of `data_i` after that edge, whatever the enables are.
- R3: When `clr_n` and `ld_n` are high and both `en_par` and `en_trk` are high, `q_o` increases by one at the edge. A lower nibble at 15 carries into the next nibble in the same edge.
- R4: When `clr_n` and `ld_n` are high and either `en_par` or `en_trk` is low, `q_o` keeps its value across the edge.
- R5: Counting from the all-ones value wraps `q_o` to all zeros.
- R6: `carry_o` is high exactly when every bit of `q_o` is one and `en_trk` is high. `carry_o` is combinational, and `en_par` has no effect on it.
- R7: The lookahead linking (`LOOKAHEAD`=1) and the ripple linking (`LOOKAHEAD`=0) produce identical `q_o` and `carry_o` under the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all slices |
| clr_n | input | 1 | Active-low synchronous clear |
| ld_n | input | 1 | Active-low synchronous parallel load |
| data_i | input | 4*SLICES | Load value; nibble k goes to slice k |
| en_par | input | 1 | Parallel count enable (counting only) |
| en_trk | input | 1 | Trickle count enable (counting and carry) |
| q_o | output | 4*SLICES | Counter state; slice 0 is the low nibble |
| carry_o | output | 1 | All-ones terminal count qualified by `en_trk` |

## Verification
Clear and load can both be requested in the same cycle. The bench forces them low together, sometimes while both enables are also high, and expects zero, so that the priority order is judged at the output. A count step at the all-ones value can also coincide with carry reporting. The bench loads values near all ones, holds the count with `en_par` low while `en_trk` is high, and then enables counting. In each cycle it checks the combinational carry before the edge and the wrapped state after it, for both linking styles.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [1:0] {
        M_CLEAR,
        M_LOAD,
        M_COUNT,
        M_HOLD
    } mode_t;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
    import cnt_pkg::*;
(
    input  logic  clr_n,
    input  logic  ld_n,
    input  logic  en_par,
    input  logic  en_trk,
    output mode_t mode
);
    // priority: clear, then load, then count, else hold
    always_comb begin
        if (!clr_n)
            mode = M_CLEAR;
        else if (!ld_n)
            mode = M_LOAD;
        else if (en_par && en_trk)
            mode = M_COUNT;
        else
            mode = M_HOLD;
    end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
#(
    parameter int NIB = 4
) (
    input  logic           clk,
    input  logic           clr_n,
    input  logic           ld_n,
    input  logic           en_par,
    input  logic           en_trk,
    input  logic [NIB-1:0] d,
    output logic [NIB-1:0] q,
    output logic           tc
);
    mode_t          mode;
    logic [NIB-1:0] q_r;
    logic [NIB-1:0] q_nx;

    cnt_mode_dec u_dec (
        .clr_n  (clr_n),
        .ld_n   (ld_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .mode   (mode)
    );

    // next-state selection per mode
    always_comb begin
        unique case (mode)
            M_CLEAR: q_nx = '0;
            M_LOAD:  q_nx = d;
            M_COUNT: q_nx = q_r + NIB'(1);
            M_HOLD:  q_nx = q_r;
            default: q_nx = q_r;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        q_r <= q_nx;
    end

    // outputs: terminal count ignores the parallel enable
    always_comb begin
        q  = q_r;
        tc = (&q_r) & en_trk;
    end
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
    parameter int SLICES    = 3,
    parameter int NIB       = 4,
    parameter bit LOOKAHEAD = 1'b1
) (
    input  logic                    clk,
    input  logic                    clr_n,
    input  logic                    ld_n,
    input  logic [SLICES*NIB-1:0]   data_i,
    input  logic                    en_par,
    input  logic                    en_trk,
    output logic [SLICES*NIB-1:0]   q_o,
    output logic                    carry_o
);
    localparam int W = SLICES * NIB;

    logic [SLICES-1:0] tc;
    logic [SLICES-1:0] ep;
    logic [SLICES-1:0] et;

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        if (g == 0) begin : g_first
            assign ep[g] = en_par;
            assign et[g] = en_trk;
        end else if (LOOKAHEAD) begin : g_look
            // slice 0 terminal count fans out to every higher parallel enable
            assign ep[g] = tc[0] & en_par;
            if (g == 1) begin : g_t1
                assign et[g] = en_trk;
            end else begin : g_tn
                assign et[g] = tc[g-1];
            end
        end else begin : g_ripple
            assign ep[g] = en_par;
            assign et[g] = tc[g-1];
        end

        cnt_slice #(.NIB(NIB)) u_slice (
            .clk    (clk),
            .clr_n  (clr_n),
            .ld_n   (ld_n),
            .en_par (ep[g]),
            .en_trk (et[g]),
            .d      (data_i[g*NIB +: NIB]),
            .q      (q_o[g*NIB +: NIB]),
            .tc     (tc[g])
        );
    end

    if (LOOKAHEAD && SLICES > 1) begin : g_carry_look
        // upper chain skips slice 0 in its trickle path, so qualify with it
        assign carry_o = tc[SLICES-1] & tc[0];
    end else begin : g_carry_rip
        assign carry_o = tc[SLICES-1];
    end
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         clr_n,
    input logic         ld_n,
    input logic [W-1:0] data_i,
    input logic         en_par,
    input logic         en_trk,
    input logic [W-1:0] q_o,
    input logic         carry_o
);
    // state is unknown until the first clear has been applied
    logic seen_clr = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) seen_clr <= 1'b1;
    end

    a_r1_clear: assert property (@(posedge clk) disable iff (!seen_clr)
        !clr_n |=> (q_o == '0));

    a_r2_load: assert property (@(posedge clk) disable iff (!seen_clr)
        (clr_n && !ld_n) |=> (q_o == $past(data_i)));

    a_r3_count: assert property (@(posedge clk) disable iff (!seen_clr)
        (clr_n && ld_n && en_par && en_trk) |=> (q_o == $past(q_o) + W'(1)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!seen_clr)
        (clr_n && ld_n && !(en_par && en_trk)) |=> $stable(q_o));

    a_r5_wrap: assert property (@(posedge clk) disable iff (!seen_clr)
        (clr_n && ld_n && en_par && en_trk && (&q_o)) |=> (q_o == '0));

    a_r6_carry: assert property (@(posedge clk) disable iff (!seen_clr)
        carry_o == ((&q_o) && en_trk));
endmodule

bind cnt_chain cnt_chain_chk #(.W(W)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .ld_n    (ld_n),
    .data_i  (data_i),
    .en_par  (en_par),
    .en_trk  (en_trk),
    .q_o     (q_o),
    .carry_o (carry_o)
);

// File: tb/tb_cnt_chain.sv
`timescale 1ns/1ps
module tb_cnt_chain;
    localparam int SLICES = 3;
    localparam int W      = SLICES * 4;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0, ld_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [W-1:0] data_i = '0;
    logic [W-1:0] q_la, q_rp;
    logic         c_la, c_rp;
    logic [W-1:0] ref_q;
    int           checks = 0, errors = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    cnt_chain #(.SLICES(SLICES), .LOOKAHEAD(1'b1)) dut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .data_i(data_i),
        .en_par(en_par), .en_trk(en_trk), .q_o(q_la), .carry_o(c_la));

    cnt_chain #(.SLICES(SLICES), .LOOKAHEAD(1'b0)) dut_rip (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .data_i(data_i),
        .en_par(en_par), .en_trk(en_trk), .q_o(q_rp), .carry_o(c_rp));

    function automatic logic [W-1:0] next_q(logic [W-1:0] q, logic c, logic l,
                                            logic [W-1:0] d, logic p, logic t);
        if (!c) return '0;
        if (!l) return d;
        if (p && t) return q + W'(1);
        return q;
    endfunction

    function automatic logic exp_carry(logic [W-1:0] q, logic t);
        return (q == ONES) && t;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a falling edge; returns just after the next falling edge
    task automatic step(logic c, logic l, logic [W-1:0] d, logic p, logic t);
        string tag;
        logic [W-1:0] prev;
        clr_n = c; ld_n = l; data_i = d; en_par = p; en_trk = t;
        #1;
        chk("R6 carry", W'(c_la), W'(exp_carry(ref_q, t)));
        chk("R7 R6 ripple carry", W'(c_rp), W'(exp_carry(ref_q, t)));
        prev = ref_q;
        @(posedge clk);
        ref_q = next_q(ref_q, c, l, d, p, t);
        @(negedge clk);
        if (!c)                 tag = "R1 clear";
        else if (!l)            tag = "R2 load";
        else if (!(p && t))     tag = "R4 hold";
        else if (prev == ONES)  tag = "R5 wrap";
        else                    tag = "R3 count";
        chk(tag, q_la, ref_q);
        chk({"R7 ripple ", tag}, q_rp, ref_q);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_r;
        seed_r = $urandom(32'd2024);
        ref_q = '0;
        @(negedge clk);
        // R1: initial clear with load and enables active
        step(1'b0, 1'b0, 12'hABC, 1'b1, 1'b1);
        // R2: load ignores disabled enables
        step(1'b1, 1'b0, 12'h0EF, 1'b0, 1'b0);
        // R3: nibble carry 0EF -> 0F0, then 0FF -> 100
        step(1'b1, 1'b1, '0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 12'h0FF, 1'b1, 1'b1);
        step(1'b1, 1'b1, '0, 1'b1, 1'b1);
        // R6: all ones, en_par low, en_trk high -> carry high, R4 hold
        step(1'b1, 1'b0, ONES, 1'b0, 1'b1);
        step(1'b1, 1'b1, '0, 1'b0, 1'b1);
        // R6: en_trk low -> carry low, hold
        step(1'b1, 1'b1, '0, 1'b1, 1'b0);
        // R5: wrap from all ones
        step(1'b1, 1'b1, '0, 1'b1, 1'b1);
        // R1: clear wins over load in the same cycle
        step(1'b1, 1'b0, 12'h5A5, 1'b1, 1'b1);
        step(1'b0, 1'b0, 12'h123, 1'b1, 1'b1);
        // lower slice at 15 with en_par low must not advance upper slices
        step(1'b1, 1'b0, 12'h0EF, 1'b1, 1'b1);
        step(1'b1, 1'b1, '0, 1'b0, 1'b1);
        step(1'b1, 1'b1, '0, 1'b1, 1'b0);
        step(1'b1, 1'b1, '0, 1'b1, 1'b1);
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] d;
            d = W'($urandom);
            if ($urandom_range(1, 0) == 1) d[7:0] = 8'hF0 | d[3:0];
            if ($urandom_range(3, 0) == 0) d = ONES - W'($urandom_range(3, 0));
            step($urandom_range(15, 0) != 0,
                 $urandom_range(9, 0) != 0,
                 d,
                 $urandom_range(3, 0) != 0,
                 $urandom_range(3, 0) != 0);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule